// File: doc/BRIEF.md
# Register Window Pointer Tracker

This block keeps the current window pointer of a windowed register file and turns the logical register numbers of each instruction into physical register indices. One instruction may enter per cycle. An instruction can be a plain operation, a save, or a restore. A save moves the pointer down by one window and a restore moves it up by one. The pointer wraps around in both directions. A save or restore still performs an add: its operands are read in the window it started from, and its result is written in the window it moves to.

The pipeline has three stages. The input cycle is decode. One register stage acts as execute. The output registers act as write-back. The decode stage owns a front pointer, and every stage holds its own copy of the pointer that applies to the instruction it carries. When the execute instruction is flushed, the front pointer falls back to the copy held for that instruction, so younger instructions see the correct window again. The physical file holds 8 global registers and 16 registers per window. The out registers of each window overlap the in registers of the window below it.

Top module: `cwp_tracker`

## Requirements
- R1: While and right after reset, `rd_valid` and `wr_en` are 0, `cur_ptr` is 0 and `cwp_commit` is 0.
- R2: `in_op` encoding is 2'b00 plain, 2'b01 save, 2'b10 restore, 2'b11 plain. An accepted save sets `cur_ptr` to (old-1) mod NWIN one cycle later, a restore sets it to (old+1) mod NWIN, and a plain op leaves it unchanged.
- R3: Logical r0..r7 map to physical 0..7 in every window. A read of logical r0 raises its zero flag, and any other register clears it.
- R4: In window w, locals r16..r23 map to 8+16w+8+(r-16), and ins r24..r31 map to 8+16w+(r-24).
- R5: In window w, outs r8..r15 map to 8+16*((w-1) mod NWIN)+(r-8). These are the same physical registers as the ins of window w-1.
- R6: The read indices of an instruction appear one cycle after it is presented, with `rd_valid`=1, and are computed with the pointer in effect before that instruction.
- R7: The write index appears two cycles after the instruction is presented, with `wr_en`=1, and is computed with the pointer after that instruction. A destination of r0 gives `wr_en`=0.
- R8: An instruction presented in the cycle right after a save or restore reads with the updated pointer.
- R9: `flush` drops the instruction in execute and the one presented in the same cycle. It returns `cur_ptr` to the pointer held before the dropped execute instruction, produces no `rd_valid` or `wr_en` for either instruction, and leaves `cwp_commit` unchanged.
- R10: `cwp_commit` takes the post-instruction pointer of each instruction when its write-back outputs appear, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction presented at decode |
| in_op | input | 2 | Operation class (plain/save/restore) |
| in_rs1 | input | 5 | First logical source register |
| in_rs2 | input | 5 | Second logical source register |
| in_rd | input | 5 | Logical destination register |
| flush | input | 1 | Squash execute and decode instructions |
| rd_valid | output | 1 | Read indices valid |
| rd_phys_a | output | clog2(NGLB+16*NWIN) | Physical index for first source |
| rd_zero_a | output | 1 | First source is r0 |
| rd_phys_b | output | clog2(NGLB+16*NWIN) | Physical index for second source |
| rd_zero_b | output | 1 | Second source is r0 |
| wr_en | output | 1 | Write enable for result |
| wr_phys | output | clog2(NGLB+16*NWIN) | Physical index for destination |
| cur_ptr | output | clog2(NWIN) | Front (decode) window pointer |
| cwp_commit | output | clog2(NWIN) | Pointer of last retired instruction |

## Verification
The hardest case to reach from the ports is a flush that lands while a save sits in execute and a second save is being presented. Getting there takes an exact two-cycle sequence: the first save is presented, and on the next cycle the second save is presented together with `flush`. The bench checks that the pointer falls back past both saves and that neither one writes. The bench also sweeps every logical register in every window, reached through chains of saves and then restores, so the pointer wraps in both directions and the overlap between outs and ins is checked at every window boundary.

// File: rtl/cwp_pkg.sv
package cwp_pkg;
  typedef enum logic [1:0] {
    OP_PLAIN   = 2'b00,
    OP_SAVE    = 2'b01,
    OP_RESTORE = 2'b10,
    OP_RSVD    = 2'b11
  } wop_e;

  localparam int LREGS   = 32;
  localparam int WSTRIDE = 16;
endpackage

// File: rtl/cwp_map.sv
module cwp_map
  import cwp_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGLB = 8,
  localparam int PW  = $clog2(NWIN),
  localparam int PHW = $clog2(NGLB + WSTRIDE * NWIN)
) (
  input  logic [4:0]    lreg,
  input  logic [PW-1:0] win,
  output logic [PHW-1:0] phys,
  output logic          is_zero
);
  logic [PW-1:0] win_prev;

  // outs of window w live in the ins of window w-1 (mod NWIN)
  assign win_prev = (win == '0) ? PW'(NWIN - 1) : win - 1'b1;
  assign is_zero  = (lreg == 5'd0);

  always_comb begin
    case (lreg[4:3])
      2'd0:    phys = PHW'(lreg);
      2'd1:    phys = PHW'(NGLB + WSTRIDE * int'(win_prev) + int'(lreg[2:0]));
      2'd2:    phys = PHW'(NGLB + WSTRIDE * int'(win) + 8 + int'(lreg[2:0]));
      default: phys = PHW'(NGLB + WSTRIDE * int'(win) + int'(lreg[2:0]));
    endcase
  end
endmodule

// File: rtl/cwp_front.sv
module cwp_front
  import cwp_pkg::*;
#(
  parameter int NWIN = 8,
  localparam int PW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  wop_e          in_op,
  input  logic          flush,
  input  logic [PW-1:0] restore_ptr,
  output logic [PW-1:0] cur_ptr,
  output logic [PW-1:0] nxt_ptr
);
  always_comb begin
    case (in_op)
      OP_SAVE:    nxt_ptr = (cur_ptr == '0) ? PW'(NWIN - 1) : cur_ptr - 1'b1;
      OP_RESTORE: nxt_ptr = (cur_ptr == PW'(NWIN - 1)) ? '0 : cur_ptr + 1'b1;
      default:    nxt_ptr = cur_ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)           cur_ptr <= '0;
    else if (flush)    cur_ptr <= restore_ptr;
    else if (in_valid) cur_ptr <= nxt_ptr;
  end

  AST_SAVE_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush && in_op == OP_SAVE) |=>
      (cur_ptr == (($past(cur_ptr) == '0) ? PW'(NWIN - 1) : $past(cur_ptr) - 1'b1))); // R2
  AST_RESTORE_STEP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !flush && in_op == OP_RESTORE) |=>
      (cur_ptr == (($past(cur_ptr) == PW'(NWIN - 1)) ? '0 : $past(cur_ptr) + 1'b1))); // R2
  AST_FLUSH_RESTORE: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cur_ptr == $past(restore_ptr))); // R9
endmodule

// File: rtl/cwp_tracker.sv
module cwp_tracker
  import cwp_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int NGLB = 8,
  localparam int PW  = $clog2(NWIN),
  localparam int PHW = $clog2(NGLB + WSTRIDE * NWIN)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [1:0]     in_op,
  input  logic [4:0]     in_rs1,
  input  logic [4:0]     in_rs2,
  input  logic [4:0]     in_rd,
  input  logic           flush,
  output logic           rd_valid,
  output logic [PHW-1:0] rd_phys_a,
  output logic           rd_zero_a,
  output logic [PHW-1:0] rd_phys_b,
  output logic           rd_zero_b,
  output logic           wr_en,
  output logic [PHW-1:0] wr_phys,
  output logic [PW-1:0]  cur_ptr,
  output logic [PW-1:0]  cwp_commit
);
  // execute-stage copy: pointer before and after the held instruction
  logic          ex_valid;
  logic [4:0]    ex_rd;
  logic [PW-1:0] ex_old;
  logic [PW-1:0] ex_new;
  logic [PW-1:0] nxt_ptr;
  logic          accept;

  assign accept = in_valid && !flush;

  cwp_front #(.NWIN(NWIN)) u_front (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_op      (wop_e'(in_op)),
    .flush      (flush),
    .restore_ptr(ex_old),
    .cur_ptr    (cur_ptr),
    .nxt_ptr    (nxt_ptr)
  );

  // read ports use the decode-stage (old) pointer
  logic [1:0][4:0] rs_l;
  logic [PHW-1:0]  rd_map [2];
  logic            rd_z   [2];
  assign rs_l = {in_rs2, in_rs1};

  for (genvar g = 0; g < 2; g++) begin : g_rd
    cwp_map #(.NWIN(NWIN), .NGLB(NGLB)) u_map (
      .lreg   (rs_l[g]),
      .win    (cur_ptr),
      .phys   (rd_map[g]),
      .is_zero(rd_z[g])
    );
  end

  // write port uses the execute-stage (new) pointer
  logic [PHW-1:0] wr_map;
  logic           wr_z;
  cwp_map #(.NWIN(NWIN), .NGLB(NGLB)) u_wmap (
    .lreg   (ex_rd),
    .win    (ex_new),
    .phys   (wr_map),
    .is_zero(wr_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_valid   <= 1'b0;
      ex_rd      <= '0;
      ex_old     <= '0;
      ex_new     <= '0;
      rd_valid   <= 1'b0;
      rd_phys_a  <= '0;
      rd_zero_a  <= 1'b0;
      rd_phys_b  <= '0;
      rd_zero_b  <= 1'b0;
      wr_en      <= 1'b0;
      wr_phys    <= '0;
      cwp_commit <= '0;
    end else begin
      ex_valid  <= accept;
      ex_rd     <= in_rd;
      ex_old    <= flush ? ex_old : cur_ptr;
      ex_new    <= accept ? nxt_ptr : (flush ? ex_old : cur_ptr);
      rd_valid  <= accept;
      rd_phys_a <= rd_map[0];
      rd_zero_a <= rd_z[0];
      rd_phys_b <= rd_map[1];
      rd_zero_b <= rd_z[1];
      wr_en     <= ex_valid && !flush && !wr_z;
      wr_phys   <= wr_map;
      if (ex_valid && !flush) cwp_commit <= ex_new;
    end
  end

  AST_WR_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_phys != '0)); // R7
  AST_FLUSH_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!wr_en && !rd_valid)); // R9
  AST_RD_FOLLOWS_IN: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(in_valid)); // R6
  AST_COMMIT_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
    !$stable(cwp_commit) |-> ($past(ex_valid) && !$past(flush))); // R10
endmodule

// File: tb/cwp_tracker_bench.sv
module cwp_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NWIN = 8;
  localparam int PHW  = 8;
  localparam int PW   = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [1:0]     in_op = 2'b00;
  logic [4:0]     in_rs1 = '0, in_rs2 = '0, in_rd = '0;
  logic           flush = 1'b0;
  logic           rd_valid, rd_zero_a, rd_zero_b, wr_en;
  logic [PHW-1:0] rd_phys_a, rd_phys_b, wr_phys;
  logic [PW-1:0]  cur_ptr, cwp_commit;

  int total = 0;
  int bad   = 0;
  int mptr  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cwp_tracker u_cwp_tracker (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rs1(in_rs1), .in_rs2(in_rs2), .in_rd(in_rd), .flush(flush),
    .rd_valid(rd_valid), .rd_phys_a(rd_phys_a), .rd_zero_a(rd_zero_a),
    .rd_phys_b(rd_phys_b), .rd_zero_b(rd_zero_b), .wr_en(wr_en),
    .wr_phys(wr_phys), .cur_ptr(cur_ptr), .cwp_commit(cwp_commit)
  );

  function automatic int phys(int r, int w);
    if (r < 8)  return r;
    if (r < 16) return 8 + 16 * ((w + NWIN - 1) % NWIN) + (r - 8);
    if (r < 24) return 16 + 16 * w + (r - 16);
    return 8 + 16 * w + (r - 24);
  endfunction

  function automatic int step(int op, int w);
    if (op == 1) return (w + NWIN - 1) % NWIN;
    if (op == 2) return (w + 1) % NWIN;
    return w;
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // presents one instruction at a negedge and checks both result cycles
  task automatic run(int op, int rs1, int rs2, int rd, string req);
    int nw;
    nw = step(op, mptr);
    in_valid = 1'b1; in_op = op[1:0];
    in_rs1 = rs1[4:0]; in_rs2 = rs2[4:0]; in_rd = rd[4:0];
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R6 rd_valid"}, int'(rd_valid), 1);
    check({req, " R6 read a"}, int'(rd_phys_a), phys(rs1, mptr));
    check({req, " R6 read b"}, int'(rd_phys_b), phys(rs2, mptr));
    check({req, " R3 zero a"}, int'(rd_zero_a), int'(rs1 == 0));
    check({req, " R2 cur_ptr"}, int'(cur_ptr), nw);
    @(negedge clk);
    check({req, " R7 wr_en"}, int'(wr_en), int'(rd != 0));
    if (rd != 0) check({req, " R7 write idx"}, int'(wr_phys), phys(rd, nw));
    check({req, " R10 commit"}, int'(cwp_commit), nw);
    mptr = nw;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_valid", int'(rd_valid), 0);
    check("R1 wr_en", int'(wr_en), 0);
    check("R1 cur_ptr", int'(cur_ptr), 0);
    check("R1 commit", int'(cwp_commit), 0);

    // R3 R4 R5 sweep every register in every window, walking down by saves
    for (int w = 0; w < NWIN; w++) begin
      for (int r = 0; r < 32; r++) run(0, r, (r + 13) % 32, r, "R4 R5 sweep");
      run(1, 10, 0, 26, "R2 save");
    end
    check("R2 save wrap back to 0", int'(cur_ptr), 0);
    // restores walk upward, across the 7->0 wrap
    for (int w = 0; w < NWIN; w++) begin
      run(2, 26, 9, 10, "R2 restore");
      run(0, 12, 27, 13, "R5 after restore");
    end
    run(3, 1, 2, 3, "R2 op 11 plain");

    // R8 back-to-back save then plain
    begin
      int w0, w1;
      w0 = mptr; w1 = step(1, w0);
      in_valid = 1'b1; in_op = 2'b01; in_rs1 = 5'd16; in_rs2 = 5'd0; in_rd = 5'd17;
      @(negedge clk);
      check("R8 save read old", int'(rd_phys_a), phys(16, w0));
      in_op = 2'b00; in_rs1 = 5'd16; in_rd = 5'd18;
      @(negedge clk);
      in_valid = 1'b0;
      check("R8 plain reads new", int'(rd_phys_a), phys(16, w1));
      check("R8 save write new", int'(wr_phys), phys(17, w1));
      @(negedge clk);
      check("R8 plain write", int'(wr_phys), phys(18, w1));
      check("R8 wr_en", int'(wr_en), 1);
      mptr = w1;
    end

    // R9 flush while a save is in execute and another save arrives
    begin
      int w0;
      w0 = mptr;
      in_valid = 1'b1; in_op = 2'b01; in_rs1 = 5'd1; in_rd = 5'd20;
      @(negedge clk);
      in_rd = 5'd21; flush = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; flush = 1'b0;
      check("R9 no rd_valid", int'(rd_valid), 0);
      check("R9 no wr_en", int'(wr_en), 0);
      check("R9 ptr restored", int'(cur_ptr), w0);
      check("R9 commit held", int'(cwp_commit), w0);
      @(negedge clk);
      check("R9 no late write", int'(wr_en), 0);
      check("R9 ptr still", int'(cur_ptr), w0);
      run(0, 20, 8, 21, "R9 after flush");
      // flush with empty execute drops the incoming save
      in_valid = 1'b1; in_op = 2'b01; flush = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; flush = 1'b0;
      check("R9 empty flush ptr", int'(cur_ptr), w0);
      check("R9 empty flush rd", int'(rd_valid), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule